// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is one output cell of a sum-of-products logic array. It receives the OR-summed term for its output, a per-cell product term that enables the three-state pad driver, and two product terms shared by every cell: one that clears the storage flip-flop at once, and one that sets it to 1 on the next clock edge. A two-bit mode code decides whether the flip-flop sits in the output path and whether the output is inverted. The cell returns a feedback bit to the array. In registered mode that bit is the flip-flop state. In combinational mode it is the level on the pin.

The pad is modelled as three data signals: a driven value, a driver enable, and the level sampled from the pin. When the driver is off, the sampled level is what the cell sees as its pin. A combinational cell whose enable term stays low therefore works as a dedicated input.

For test, a preload request copies the pin level straight into the flip-flop. This lets a state machine built from these cells be forced into any state, including illegal ones. A lock input blocks the preload path.

Top module: `sop_out_cell`

## Requirements
- R1: The mode code `mode_cfg` is decoded as follows. Bit 1 = 0 selects registered mode and bit 1 = 1 selects combinational mode. Bit 0 = 0 selects active-low output and bit 0 = 1 selects active-high output. The four codes are 00 registered/low, 01 registered/high, 10 combinational/low and 11 combinational/high.
- R2: In registered mode the flip-flop captures `sum_in` on each rising clock edge. `pad_out` equals the state in active-high mode and its inverse in active-low mode.
- R3: In combinational mode `pad_out` equals `sum_in` (active-high) or its inverse (active-low), with no clock delay.
- R4: `fb_out` is the flip-flop state in registered mode. In combinational mode it is the pin level: `pad_out` while the driver is enabled, and `pad_in` while it is disabled.
- R5: While `ar_term` is high the flip-flop is 0 at once, without a clock edge. This term overrides the preset, the preload and data capture.
- R6: `sp_term` high loads 1 into the flip-flop at the next rising edge. It overrides the preload and data capture.
- R7: Clear and preset act on the flip-flop state, not on the pin. A cleared register in active-low mode drives the pin high.
- R8: `pad_oe` follows `oe_term`. A combinational cell with its driver disabled returns `pad_in` as feedback.
- R9: While `rst_n` is low the flip-flop holds 0.
- R10: With `preload_en` high and `lock` low, the next rising edge loads the pin level into the flip-flop, in place of `sum_in`. With `lock` high, the preload request is ignored and the cell captures `sum_in` as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Array clock, rising edge |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| mode_cfg | input | 2 | Mode code (bit 1 bypass, bit 0 polarity) |
| sum_in | input | 1 | Sum term from the OR array |
| oe_term | input | 1 | Output-enable product term |
| ar_term | input | 1 | Shared asynchronous clear term |
| sp_term | input | 1 | Shared synchronous preset term |
| preload_en | input | 1 | Test request to load the flip-flop from the pin |
| lock | input | 1 | Security lock; blocks preload |
| pad_in | input | 1 | Level sampled from the pin |
| pad_out | output | 1 | Value driven to the pin |
| pad_oe | output | 1 | Pin driver enable |
| fb_out | output | 1 | Feedback to the array |

## Verification
A vector table runs the two combinational codes with each sum value, driver on and off, and a pin level that differs from the driven value. This shows whether feedback is taken from the pin or from the driven value, and whether inversion is applied. Directed clocked sequences step both registered polarities through alternating sum values. The sum is held opposite to the expected state wherever a clear, preset or preload must win, so the priority between them shows at the feedback output. The clear is also observed between clock edges, to show that it takes effect without a clock. A locked preload is given a pin level that disagrees with `sum_in`, so an ignored request can be told apart from an accepted one.

// File: rtl/mc_pkg.sv
package mc_pkg;
   typedef enum logic [1:0] {
      MC_REG_LOW  = 2'b00,
      MC_REG_HIGH = 2'b01,
      MC_CMB_LOW  = 2'b10,
      MC_CMB_HIGH = 2'b11
   } mc_mode_e;

   localparam int MC_MODE_W = 2;
endpackage

// File: rtl/mc_mode_dec.sv
module mc_mode_dec
   import mc_pkg::*;
#(
   parameter int MODE_W = MC_MODE_W
) (
   input  logic [MODE_W-1:0] mode_cfg,
   output logic              bypass,
   output logic              invert
);
   localparam int BYP_BIT = MODE_W - 1;
   localparam int POL_BIT = 0;

   initial begin
      if (MODE_W != MC_MODE_W)
         $error("mc_mode_dec: MODE_W must equal %0d", MC_MODE_W);
   end

   mc_mode_e mode;
   always_comb begin
      mode   = mc_mode_e'(mode_cfg);
      bypass = mode_cfg[BYP_BIT];
      invert = ~mode_cfg[POL_BIT];
   end

   // R1: the code splits into exactly two independent controls
   always_comb begin
      if (!$isunknown(mode_cfg)) begin
         a_r1_code_split: assert ((bypass == (mode == MC_CMB_LOW || mode == MC_CMB_HIGH)) &&
                                  (invert == (mode == MC_REG_LOW || mode == MC_CMB_LOW)));
      end
   end
endmodule

// File: rtl/mc_state_reg.sv
module mc_state_reg #(
   parameter bit ALLOW_PRELOAD = 1'b1,
   parameter bit POWERUP_VAL   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_async,
   input  logic set_sync,
   input  logic d,
   input  logic pl_req,
   input  logic pl_data,
   input  logic lock,
   output logic q
);
   logic pl_take;

   generate
      if (ALLOW_PRELOAD) begin : g_pl
         assign pl_take = pl_req & ~lock;
      end else begin : g_no_pl
         logic unused_pl;
         assign unused_pl = pl_req ^ lock;
         assign pl_take   = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n or posedge clr_async) begin
      if (!rst_n) begin
         q <= POWERUP_VAL;
      end else if (clr_async) begin
         q <= 1'b0;
      end else if (set_sync) begin
         q <= 1'b1;
      end else if (pl_take) begin
         q <= pl_data;
      end else begin
         q <= d;
      end
   end

   // R5: state is low whenever the clear term is sampled high
   a_r5_clear_now: assert property (@(posedge clk) disable iff (!rst_n)
      clr_async |-> (q == 1'b0));

   // R6: preset wins over preload and data
   a_r6_preset_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_async && set_sync) |=> (clr_async || q == 1'b1));

   // R2 and R10: with no override, the state follows the sum term
   a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_async && !set_sync && !pl_take) |=> (clr_async || q == $past(d)));

   // R10: an accepted preload loads the pin level
   a_r10_preload: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_async && !set_sync && pl_take) |=> (clr_async || q == $past(pl_data)));
endmodule

// File: rtl/mc_pin_path.sv
module mc_pin_path (
   input  logic bypass,
   input  logic invert,
   input  logic q,
   input  logic sum_in,
   input  logic oe_term,
   input  logic pad_in,
   output logic pad_out,
   output logic pad_oe,
   output logic pin_lvl,
   output logic fb_out
);
   logic pre_pol;

   always_comb begin
      pre_pol = bypass ? sum_in : q;
      pad_out = pre_pol ^ invert;
      pad_oe  = oe_term;
      pin_lvl = oe_term ? pad_out : pad_in;
      fb_out  = bypass ? pin_lvl : q;
   end

   // R8: a disabled driver leaves the feedback to the external level
   always_comb begin
      if (!$isunknown({bypass, oe_term, pad_in})) begin
         a_r8_input_mode: assert (!(bypass && !oe_term) || fb_out == pad_in);
      end
   end
endmodule

// File: rtl/sop_out_cell.sv
module sop_out_cell
   import mc_pkg::*;
#(
   parameter int MODE_W        = MC_MODE_W,
   parameter bit ALLOW_PRELOAD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_cfg,
   input  logic              sum_in,
   input  logic              oe_term,
   input  logic              ar_term,
   input  logic              sp_term,
   input  logic              preload_en,
   input  logic              lock,
   input  logic              pad_in,
   output logic              pad_out,
   output logic              pad_oe,
   output logic              fb_out
);
   logic bypass;
   logic invert;
   logic q;
   logic pin_lvl;

   mc_mode_dec #(.MODE_W(MODE_W)) i_dec (
      .mode_cfg (mode_cfg),
      .bypass   (bypass),
      .invert   (invert)
   );

   mc_state_reg #(.ALLOW_PRELOAD(ALLOW_PRELOAD), .POWERUP_VAL(1'b0)) i_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_async (ar_term),
      .set_sync  (sp_term),
      .d         (sum_in),
      .pl_req    (preload_en),
      .pl_data   (pin_lvl),
      .lock      (lock),
      .q         (q)
   );

   mc_pin_path i_pin (
      .bypass  (bypass),
      .invert  (invert),
      .q       (q),
      .sum_in  (sum_in),
      .oe_term (oe_term),
      .pad_in  (pad_in),
      .pad_out (pad_out),
      .pad_oe  (pad_oe),
      .pin_lvl (pin_lvl),
      .fb_out  (fb_out)
   );

   // R3 and R4: an enabled combinational active-high cell feeds the sum term back
   a_r4_comb_fb: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_cfg == MC_CMB_HIGH && oe_term) |-> (fb_out == sum_in));

   // R7: a cleared register in active-low mode drives the pin high
   a_r7_clear_pin: assert property (@(posedge clk) disable iff (!rst_n)
      (ar_term && mode_cfg == MC_REG_LOW) |-> (pad_out == 1'b1));
endmodule

// File: tb/test_sop_out_cell.sv
module test_sop_out_cell;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] mode_cfg;
   logic       sum_in, oe_term, ar_term, sp_term, preload_en, lock, pad_in;
   logic       pad_out, pad_oe, fb_out;
   int         total = 0;
   int         bad = 0;

   always #10 clk = ~clk;

   sop_out_cell i_sop_out_cell (
      .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .sum_in(sum_in),
      .oe_term(oe_term), .ar_term(ar_term), .sp_term(sp_term),
      .preload_en(preload_en), .lock(lock), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .fb_out(fb_out)
   );

   // entry: {mode[1:0], sum, oe, pin, exp_out, exp_oe, exp_fb}
   localparam int NVEC = 6;
   localparam logic [7:0] VEC [NVEC] = '{
      8'b11_1_1_0_1_1_1,   // R3 comb high, driven, fb from driven value
      8'b11_0_1_1_0_1_0,   // R4 pin level ignored while driving
      8'b10_1_1_0_0_1_0,   // R1 code 10 inverts
      8'b10_0_1_0_1_1_1,
      8'b11_1_0_0_1_0_0,   // R8 driver off: fb = pad_in
      8'b10_1_0_1_0_0_1
   };

   task automatic chk(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #4_000_000;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 0; mode_cfg = 2'b00; sum_in = 1; oe_term = 1; ar_term = 0;
      sp_term = 0; preload_en = 0; lock = 0; pad_in = 0;
      @(negedge clk); @(negedge clk);
      chk("R9 reset state", fb_out, 1'b0);
      chk("R7 reset active-low pin", pad_out, 1'b1);

      for (int i = 0; i < NVEC; i++) begin
         {mode_cfg, sum_in, oe_term, pad_in} = VEC[i][7:3];
         #1;
         chk($sformatf("R3 vec%0d pad_out", i), pad_out, VEC[i][2]);
         chk($sformatf("R8 vec%0d pad_oe", i), pad_oe, VEC[i][1]);
         chk($sformatf("R4 vec%0d fb_out", i), fb_out, VEC[i][0]);
      end

      @(negedge clk);
      rst_n = 1; mode_cfg = 2'b01; oe_term = 1; sum_in = 1;
      tick;
      chk("R2 capture 1 fb", fb_out, 1'b1);
      chk("R2 capture 1 pin high", pad_out, 1'b1);
      sum_in = 0;
      tick;
      chk("R2 capture 0 fb", fb_out, 1'b0);
      mode_cfg = 2'b00; #1;
      chk("R1 code 00 inverts", pad_out, 1'b1);
      sum_in = 1;
      tick;
      chk("R2 active-low state 1", pad_out, 1'b0);

      ar_term = 1; #2;
      chk("R5 clear without edge", fb_out, 1'b0);
      chk("R7 cleared active-low pin", pad_out, 1'b1);
      sp_term = 1;
      tick;
      chk("R5 clear beats preset", fb_out, 1'b0);
      ar_term = 0; sum_in = 0;
      tick;
      chk("R6 preset loads 1", fb_out, 1'b1);
      chk("R7 preset active-low pin", pad_out, 1'b0);
      sp_term = 0;

      mode_cfg = 2'b01; oe_term = 0; sum_in = 0; pad_in = 1; preload_en = 1;
      tick;
      chk("R10 preload pin 1", fb_out, 1'b1);
      sum_in = 1; pad_in = 0;
      tick;
      chk("R10 preload pin 0", fb_out, 1'b0);
      lock = 1; sum_in = 0; pad_in = 1;
      tick;
      chk("R10 lock blocks preload", fb_out, 1'b0);
      sum_in = 1; pad_in = 0;
      tick;
      chk("R10 locked captures sum", fb_out, 1'b1);
      lock = 0; pad_in = 0; sum_in = 0; sp_term = 1;
      tick;
      chk("R6 preset beats preload", fb_out, 1'b1);
      sp_term = 0; preload_en = 0;

      mode_cfg = 2'b11; oe_term = 0; pad_in = 1; sum_in = 0;
      tick;
      chk("R8 input mode fb", fb_out, 1'b1);
      chk("R8 input mode oe", pad_oe, 1'b0);

      rst_n = 0; mode_cfg = 2'b01; #2;
      chk("R9 async reset", fb_out, 1'b0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule